// File: doc/BRIEF.md
# Processor Status Register with Condition Flags

This block holds a 32-bit processor status word. Its top four bits are the condition flags: negative, zero, carry and overflow. The ALU presents the two operands, the result it produced and the operation class (add, subtract/compare or logical). When the flag-update enable is high on a clock edge, the block derives the four flags from those values and stores them. All other bits keep their values.

The low byte of the word is the control byte. It holds two interrupt-mask bits, a state bit and a 5-bit mode field. Software can load the entire word through a write port. While the current mode is the unprivileged user mode, that write is blocked from the control byte and only bits 31 to 8 take the new value. The stored word is always visible on the output. Downstream logic decodes the flag bits at their fixed positions and the mode field in bits 4 to 0.

Top module: `psr_unit`

## Requirements
- R1: A clock edge with `rst_n` low loads the word 0x000000D3: flags cleared, I (bit 7) and F (bit 6) set, T (bit 5) clear, and mode 5'b10011.
- R2: When neither `sw_we` nor `flag_en` is high, every bit of `psr_q` holds.
- R3: On a flag update, bit 31 (N) takes the most significant bit of `alu_result`, and bit 30 (Z) is 1 exactly when `alu_result` is all zeros. This applies to every operation code.
- R4: For op 2'b00 (add), bit 29 (C) is 1 exactly when the unsigned sum of `opnd_a` and `opnd_b` carries out of the top bit.
- R5: For op 2'b01 (subtract/compare, `opnd_a` minus `opnd_b`), C is 1 when no borrow occurs (`opnd_a` >= `opnd_b` unsigned) and 0 on a borrow.
- R6: For add, bit 28 (V) is 1 exactly when both operands share a sign and the result's sign differs from it. Operands of opposite sign never set V.
- R7: For subtract, V is 1 exactly when the operands differ in sign and the result's sign differs from the sign of `opnd_a`.
- R8: For op 2'b10 and 2'b11 (logical), N and Z update as in R3, while C and V keep their previous values.
- R9: A flag update leaves bits 27 to 0 unchanged.
- R10: A software write issued while the stored mode field (bits 4:0) is not 5'b10000 replaces all 32 bits with `sw_wdata`.
- R11: A software write issued while the stored mode is 5'b10000 (user) replaces bits 31 to 8 and leaves bits 7 to 0 unchanged.
- R12: When `sw_we` and `flag_en` are high on the same edge, the software write wins and the flag update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_en | input | 1 | Store flags derived from the ALU inputs |
| alu_op | input | 2 | Operation class: 00 add, 01 subtract, 10/11 logical |
| opnd_a | input | 32 | First ALU operand (minuend for subtract) |
| opnd_b | input | 32 | Second ALU operand (subtrahend for subtract) |
| alu_result | input | 32 | Result produced by the ALU |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| psr_q | output | 32 | Current status word |

## Verification
The hardest state to reach is user mode. A software write can enter it, but nothing except reset leaves it. For that reason the bench first walks its flag vectors in the privileged reset mode. It then uses a privileged write to drop into user mode and tries to overwrite the control byte from there. It also confirms that flag updates still work in user mode and then resets again to recover. The logical-operation vectors are ordered right after vectors that leave C and V set, so that a design which clears those flags instead of keeping them shows a visible difference.

// File: rtl/psr_pkg.sv
// Package: shared constants and types for the status register unit.
// Assumes a 32-bit status word with the flags in the top four bits.
package psr_pkg;
    localparam int PSR_W    = 32;
    localparam int CTRL_W   = 8;
    localparam int MODE_W   = 5;
    localparam int FLAG_LO  = PSR_W - 4;

    typedef enum logic [1:0] {
        ALU_ADD       = 2'b00,
        ALU_SUB       = 2'b01,
        ALU_LOGIC     = 2'b10,
        ALU_LOGIC_ALT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
    localparam logic [PSR_W-1:0]  PSR_RESET = 32'h0000_00D3;
endpackage

// File: rtl/psr_flag_calc.sv
// Module: psr_flag_calc
// Derives N, Z, C and V from the ALU operands, result and operation class.
// Assumes alu result is supplied by the ALU; carry is recomputed from operands
// by comparison. Logical ops pass the previous C and V through.
module psr_flag_calc
    import psr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    input  logic              c_prev,
    input  logic              v_prev,
    output nzcv_t             flags
);
    localparam int MSB = DATA_W - 1;

    logic add_carry;
    logic sub_carry;
    logic add_ovf;
    logic sub_ovf;

    // Carry and overflow candidates for both arithmetic classes.
    always_comb begin
        add_carry = (a > ~b);
        sub_carry = (a >= b);
        add_ovf   = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
        sub_ovf   = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
    end

    // Select the flag set for the current operation class.
    always_comb begin
        flags.n = res[MSB];
        flags.z = (res == '0);
        unique case (op)
            ALU_ADD: begin
                flags.c = add_carry;
                flags.v = add_ovf;
            end
            ALU_SUB: begin
                flags.c = sub_carry;
                flags.v = sub_ovf;
            end
            default: begin
                flags.c = c_prev;
                flags.v = v_prev;
            end
        endcase
    end

    // Immediate checks on operand corner cases.
    always_comb begin
        if (op == ALU_ADD && a[MSB] && b[MSB]) begin
            assert_add_top_carry_R4: assert (flags.c);
        end
        if (op == ALU_ADD && a[MSB] != b[MSB]) begin
            assert_add_mixed_no_ovf_R6: assert (!flags.v);
        end
        if (op == ALU_SUB && a == b) begin
            assert_sub_equal_no_borrow_R5: assert (flags.c && !flags.v);
        end
        if (op == ALU_SUB && a[MSB] == b[MSB]) begin
            assert_sub_same_sign_no_ovf_R7: assert (!flags.v);
        end
        if (op == ALU_LOGIC || op == ALU_LOGIC_ALT) begin
            assert_logic_keeps_cv_R8: assert (flags.c == c_prev && flags.v == v_prev);
        end
    end
endmodule

// File: rtl/psr_write_merge.sv
// Module: psr_write_merge
// Forms the word stored on a software write, protecting the control byte
// while the current mode is user mode. Assumes mode sits in the low bits.
module psr_write_merge
    import psr_pkg::*;
#(
    parameter int WORD_W = PSR_W,
    parameter int LOW_W  = CTRL_W
) (
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] merged
);
    logic privileged;

    // Any mode other than user may rewrite the control byte.
    always_comb begin
        privileged = (cur[MODE_W-1:0] != MODE_USER);
        if (privileged) begin
            merged = wdata;
        end else begin
            merged = {wdata[WORD_W-1:LOW_W], cur[LOW_W-1:0]};
        end
    end

    // Unprivileged merge must leave the low byte untouched.
    always_comb begin
        if (!privileged) begin
            assert_user_ctrl_kept_R11: assert (merged[LOW_W-1:0] == cur[LOW_W-1:0]);
        end
    end
endmodule

// File: rtl/psr_unit.sv
// Module: psr_unit (top)
// Holds the 32-bit status word. Flags update from ALU inputs when flag_en is
// high; a software write takes priority and is gated by privilege.
// Assumes synchronous active-low reset.
module psr_unit
    import psr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_en,
    input  logic [1:0]        alu_op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              sw_we,
    input  logic [PSR_W-1:0]  sw_wdata,
    output logic [PSR_W-1:0]  psr_q
);
    localparam int BIT_N = PSR_W - 1;
    localparam int BIT_Z = PSR_W - 2;
    localparam int BIT_C = PSR_W - 3;
    localparam int BIT_V = PSR_W - 4;

    nzcv_t              new_flags;
    logic [PSR_W-1:0]   sw_word;
    logic [PSR_W-1:0]   psr_r;

    psr_flag_calc #(.DATA_W(DATA_W)) u_flags (
        .op     (alu_op_e'(alu_op)),
        .a      (opnd_a),
        .b      (opnd_b),
        .res    (alu_result),
        .c_prev (psr_r[BIT_C]),
        .v_prev (psr_r[BIT_V]),
        .flags  (new_flags)
    );

    psr_write_merge #(.WORD_W(PSR_W), .LOW_W(CTRL_W)) u_merge (
        .cur    (psr_r),
        .wdata  (sw_wdata),
        .merged (sw_word)
    );

    // Status word register: reset, software write, then flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psr_r <= PSR_RESET;
        end else if (sw_we) begin
            psr_r <= sw_word;
        end else if (flag_en) begin
            psr_r <= {new_flags, psr_r[FLAG_LO-1:0]};
        end
    end

    assign psr_q = psr_r;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !flag_en) |=> $stable(psr_q));

    assert_flag_low_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !sw_we) |=> psr_q[FLAG_LO-1:0] == $past(psr_q[FLAG_LO-1:0]));

    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !sw_we && alu_result == '0) |=> psr_q[BIT_Z]);

    assert_neg_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !sw_we) |=> psr_q[BIT_N] == $past(alu_result[DATA_W-1]));

    assert_logic_cv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !sw_we && alu_op[1]) |=> psr_q[BIT_C:BIT_V] == $past(psr_q[BIT_C:BIT_V]));

    assert_user_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && psr_q[MODE_W-1:0] == MODE_USER) |=> psr_q[CTRL_W-1:0] == $past(psr_q[CTRL_W-1:0]));

    assert_sw_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && flag_en) |=> psr_q[PSR_W-1:CTRL_W] == $past(sw_wdata[PSR_W-1:CTRL_W]));

    assert_priv_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && psr_q[MODE_W-1:0] != MODE_USER) |=> psr_q == $past(sw_wdata));
endmodule

// File: tb/psr_unit_tb.sv
`timescale 1ns/1ps
module psr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        flag_en;
    logic [1:0]  alu_op;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] alu_result;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic [31:0] psr_q;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    psr_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_en    (flag_en),
        .alu_op     (alu_op),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .alu_result (alu_result),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .psr_q      (psr_q)
    );

    // Vector: op, a, b, result, expected NZCV. Low bits stay at 0xD3 (R9).
    localparam int NVEC = 12;
    localparam logic [101:0] VEC [NVEC] = '{
        {2'b00, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h55555554, 4'b0011},
        {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1001},
        {2'b00, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0110},
        {2'b00, 32'h00000005, 32'h00000003, 32'h00000008, 4'b0000},
        {2'b01, 32'h00000000, 32'h000000FF, 32'hFFFFFF01, 4'b1000},
        {2'b01, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0110},
        {2'b01, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011},
        {2'b10, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 4'b0111},
        {2'b11, 32'h00000000, 32'hFFFFFFFF, 32'h80000000, 4'b1011},
        {2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 4'b1001},
        {2'b00, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 4'b1000},
        {2'b01, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 4'b1000}
    };

    // Compare the status word against an expected value.
    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (psr_q !== exp) begin
            failures++;
            $display("FAIL %s: psr_q=%08h expected=%08h", req, psr_q, exp);
        end
    endtask

    // Drive inputs for one edge at a negedge and return at the next negedge.
    task automatic step(input logic fe, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] r,
                        input logic we, input logic [31:0] wd);
        flag_en = fe; alu_op = op; opnd_a = a; opnd_b = b; alu_result = r;
        sw_we = we; sw_wdata = wd;
        @(negedge clk);
        flag_en = 1'b0; sw_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: cycles=20000 expected=completion");
        finish_run();
    end

    initial begin
        flag_en = 1'b0; alu_op = 2'b00; opnd_a = '0; opnd_b = '0;
        alu_result = '0; sw_we = 1'b0; sw_wdata = '0; rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1 reset value", 32'h000000D3);

        // R2: idle cycles with busy inputs change nothing.
        opnd_a = 32'hFFFFFFFF; opnd_b = 32'h1; alu_result = 32'h0; sw_wdata = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        check("R2 idle hold", 32'h000000D3);

        // R3..R9: vector walk in supervisor mode.
        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, VEC[i][101:100], VEC[i][99:68], VEC[i][67:36], VEC[i][35:4],
                 1'b0, 32'h0);
            check($sformatf("R3/R4/R5/R6/R7/R8/R9 vector %0d", i),
                  {VEC[i][3:0], 28'h00000D3});
        end

        // R2: hold again after flags are set.
        repeat (2) @(negedge clk);
        check("R2 hold after update", 32'h800000D3);

        // R10: privileged write replaces the whole word.
        step(1'b0, 2'b00, '0, '0, '0, 1'b1, 32'h500000D1);
        check("R10 privileged full write", 32'h500000D1);

        // R12: write beats a simultaneous flag update.
        step(1'b1, 2'b00, 32'hFFFFFFFF, 32'h1, 32'h0, 1'b1, 32'h0000001F);
        check("R12 write priority", 32'h0000001F);

        // R10: enter user mode via a privileged write.
        step(1'b0, 2'b00, '0, '0, '0, 1'b1, 32'hF0000010);
        check("R10 enter user mode", 32'hF0000010);

        // R11: user write cannot touch the control byte.
        step(1'b0, 2'b00, '0, '0, '0, 1'b1, 32'h200000DF);
        check("R11 user write masked", 32'h20000010);

        // R11: flag updates still work in user mode.
        step(1'b1, 2'b00, 32'h1, 32'h1, 32'h2, 1'b0, 32'h0);
        check("R11 user flag update", 32'h00000010);

        // R1: reset recovers from user mode.
        do_reset();
        check("R1 reset from user", 32'h000000D3);

        finish_run();
    end
endmodule